// File: doc/BRIEF.md
# LPC Target Cycle Responder

This block is the target end of a Low Pin Count bus for I/O reads and writes and for DMA transfers of one, two or four bytes. It watches the framing strobe and the four-bit multiplexed bus for a cycle start. It then collects the cycle type, the address or the DMA channel and size, and any write data. Each byte is presented to a local register port. The responder drives SYNC nibbles and read data back onto the bus, and it adds wait-state SYNCs for as long as the local side holds the request back.

The local side is a valid/ready interface. The responder raises `req_valid` in the second turnaround clock before each SYNC phase. While `req_ready` is low, `req_valid` and all request fields stay high and stable. There is no limit on how long the local side may stall. The exception is a cycle aborted by the framing strobe: that withdraws the request at once. The response (`rsp_err`, `rsp_rdata`) is sampled in the clock where `req_valid` and `req_ready` are both high and the framing strobe is high. A `req_ready` seen in a clock where the framing strobe is low does not count as a handshake.

Top module: `lpc_resp`

## Requirements
- R1: While reset is low and in the first clock after it, `lad_oe` and `req_valid` are low.
- R2: A cycle starts only when `lad_in` = 0000 in the last clock with `lframe_n` low. The next nibble selects the cycle: 0000 is an I/O read, 0010 an I/O write, 1000 a DMA read and 1010 a DMA write. A bad start nibble or any other type nibble is ignored: LAD stays released and no request is made.
- R3: On an I/O cycle, four address nibbles arrive most significant first and form `req_addr`. On a write, two data nibbles arrive low nibble first and form `req_wdata`.
- R4: Each SYNC phase follows two released turnaround clocks. `req_valid` rises in the second of them and holds with stable fields until accepted. If it is accepted in that clock, the first SYNC clock already carries the ready code.
- R5: Each SYNC clock before acceptance drives a wait code: 0110 on I/O cycles and 0101 on DMA cycles. One cycle never mixes the two codes.
- R6: The clock after acceptance drives 1010 if `rsp_err` was set. Otherwise it drives 1001 when further DMA bytes follow, and 0000 when none follow.
- R7: On a read, the two clocks directly after the ready or error code carry `rsp_rdata`, low nibble first. This also happens after an error code.
- R8: On a DMA cycle, the nibble after the type sets the channel: bits 2..0 go to `req_chan` and bit 3 to `req_tc`. The next nibble sets the size in bits 1..0: 00 is one byte, 01 is two bytes, and 10 or 11 is four bytes. `req_last` is high on the final byte, and always on I/O cycles.
- R9: An error on any DMA byte ends the transfer. No further request or data phase follows.
- R10: After the final byte there are two released clocks, then idle. Between bytes of a DMA write, two released clocks come before the next write data. Between bytes of a DMA read, the next byte's turnaround follows the data directly.
- R11: `lframe_n` low in any clock aborts the cycle. In the next clock LAD is released and `req_valid` is low, and start detection applies to that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lframe_n | input | 1 | Active-low cycle framing strobe |
| lad_in | input | 4 | Bus nibble as seen by the target |
| lad_out | output | 4 | Nibble driven by the target (1111 when released) |
| lad_oe | output | 1 | Drive enable for `lad_out` |
| req_valid | output | 1 | A byte transfer is offered to the local side |
| req_ready | input | 1 | Local side accepts the offered transfer |
| req_write | output | 1 | Transfer is a write to the local side |
| req_dma | output | 1 | Transfer belongs to a DMA cycle |
| req_addr | output | ADDR_W | I/O address |
| req_chan | output | 3 | DMA channel |
| req_tc | output | 1 | DMA terminal-count flag |
| req_last | output | 1 | Final byte of the cycle |
| req_wdata | output | 8 | Write data |
| rsp_err | input | 1 | Local side reports an error |
| rsp_rdata | input | 8 | Read data from the local side |

## Verification
The bench checks the wait code on I/O and DMA cycles with stalls of zero, several and twenty clocks. A design that mixed the codes, or that inserted a wait when the local side was already ready, would fail these checks. Errors on reads, on writes, and in the middle of four-byte DMA transfers test that the data nibbles still follow on a read and that the remaining bytes are dropped. A design that kept going would raise `req_valid` again. Aborts during a wait phase and during address collection, together with bad start and bad type nibbles, check that nothing is driven afterwards. A design with a sticky state would drive LAD or hold the request.

// File: rtl/lpc_resp_pkg.sv
package lpc_resp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CTYPE, ST_ADDR, ST_CHAN, ST_SIZE, ST_WD0, ST_WD1,
    ST_TARA, ST_TARB, ST_SWAIT, ST_SDONE, ST_RD0, ST_RD1, ST_ENDA, ST_ENDB
  } st_e;

  localparam logic [3:0] START_CODE = 4'b0000;
  localparam logic [3:0] SYNC_READY = 4'b0000;
  localparam logic [3:0] SYNC_MORE  = 4'b1001;
  localparam logic [3:0] SYNC_SHORT = 4'b0101;
  localparam logic [3:0] SYNC_LONG  = 4'b0110;
  localparam logic [3:0] SYNC_ERR   = 4'b1010;
  localparam logic [3:0] BUS_IDLE   = 4'b1111;

  localparam int CNT_W = 2;  // bytes remaining after the current one (0..3)

  // size nibble bits 1..0 -> bytes remaining after the first
  function automatic logic [CNT_W-1:0] size_to_left(input logic [1:0] s);
    return s[1] ? CNT_W'(3) : CNT_W'(s[0]);
  endfunction

endpackage

// File: rtl/lpc_resp_fsm.sv
module lpc_resp_fsm
  import lpc_resp_pkg::*;
#(
  parameter int ADDR_NIBS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lframe_n,
  input  logic [3:0] lad_in,
  input  logic       req_ready,
  input  logic       rsp_err,
  output st_e        state,
  output logic       is_dma,
  output logic       is_write,
  output logic       more_q,
  output logic       err_q,
  output logic       req_valid,
  output logic       req_last
);
  localparam int NIB_W = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1;
  localparam logic [NIB_W-1:0] NIB_LAST = NIB_W'(ADDR_NIBS - 1);

  logic [NIB_W-1:0] nib_q;
  logic [CNT_W-1:0] left_q;

  assign req_valid = (state == ST_TARB) || (state == ST_SWAIT);
  assign req_last  = (left_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      is_dma   <= 1'b0;
      is_write <= 1'b0;
      more_q   <= 1'b0;
      err_q    <= 1'b0;
      nib_q    <= '0;
      left_q   <= '0;
    end else if (!lframe_n) begin
      // framing strobe low: abort anything in flight, re-evaluate start
      state <= (lad_in == START_CODE) ? ST_CTYPE : ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: state <= ST_IDLE;
        ST_CTYPE: begin
          is_write <= lad_in[1];
          more_q   <= 1'b0;
          err_q    <= 1'b0;
          nib_q    <= '0;
          left_q   <= '0;
          if (lad_in[0] == 1'b0 && lad_in[3:2] == 2'b00) begin
            is_dma <= 1'b0;
            state  <= ST_ADDR;
          end else if (lad_in[0] == 1'b0 && lad_in[3:2] == 2'b10) begin
            is_dma <= 1'b1;
            state  <= ST_CHAN;
          end else begin
            state  <= ST_IDLE;
          end
        end
        ST_ADDR: begin
          nib_q <= nib_q + NIB_W'(1);
          if (nib_q == NIB_LAST) state <= is_write ? ST_WD0 : ST_TARA;
        end
        ST_CHAN: state <= ST_SIZE;
        ST_SIZE: begin
          left_q <= size_to_left(lad_in[1:0]);
          state  <= is_write ? ST_WD0 : ST_TARA;
        end
        ST_WD0: state <= ST_WD1;
        ST_WD1: state <= ST_TARA;
        ST_TARA: state <= ST_TARB;
        ST_TARB, ST_SWAIT: begin
          if (req_ready) begin
            err_q  <= rsp_err;
            more_q <= (left_q != '0) && !rsp_err;
            if (left_q != '0) left_q <= left_q - CNT_W'(1);
            state  <= ST_SDONE;
          end else begin
            state  <= ST_SWAIT;
          end
        end
        ST_SDONE: state <= is_write ? ST_ENDA : ST_RD0;
        ST_RD0: state <= ST_RD1;
        ST_RD1: state <= more_q ? ST_TARA : ST_ENDA;
        ST_ENDA: state <= ST_ENDB;
        ST_ENDB: state <= (is_write && more_q) ? ST_WD0 : ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lpc_resp_capture.sv
module lpc_resp_capture
  import lpc_resp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lframe_n,
  input  st_e               state,
  input  logic [3:0]        lad_in,
  input  logic              hs,
  input  logic [7:0]        rsp_rdata,
  output logic [ADDR_W-1:0] addr,
  output logic [2:0]        chan,
  output logic              tc,
  output logic [7:0]        wdata,
  output logic [7:0]        rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr  <= '0;
      chan  <= '0;
      tc    <= 1'b0;
      wdata <= '0;
      rdata <= '0;
    end else begin
      if (lframe_n) begin
        if (state == ST_ADDR) addr <= {addr[ADDR_W-5:0], lad_in};
        if (state == ST_CHAN) begin
          chan <= lad_in[2:0];
          tc   <= lad_in[3];
        end
        if (state == ST_WD0) wdata[3:0] <= lad_in;
        if (state == ST_WD1) wdata[7:4] <= lad_in;
      end
      if (hs) rdata <= rsp_rdata;
    end
  end

endmodule

// File: rtl/lpc_resp_drive.sv
module lpc_resp_drive
  import lpc_resp_pkg::*;
(
  input  st_e        state,
  input  logic       is_dma,
  input  logic       more_q,
  input  logic       err_q,
  input  logic [7:0] rdata,
  output logic [3:0] lad_out,
  output logic       lad_oe
);

  always_comb begin
    lad_oe  = 1'b0;
    lad_out = BUS_IDLE;
    case (state)
      ST_SWAIT: begin
        lad_oe  = 1'b1;
        lad_out = is_dma ? SYNC_SHORT : SYNC_LONG;
      end
      ST_SDONE: begin
        lad_oe  = 1'b1;
        lad_out = err_q ? SYNC_ERR : ((is_dma && more_q) ? SYNC_MORE : SYNC_READY);
      end
      ST_RD0: begin
        lad_oe  = 1'b1;
        lad_out = rdata[3:0];
      end
      ST_RD1: begin
        lad_oe  = 1'b1;
        lad_out = rdata[7:4];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lpc_resp.sv
module lpc_resp
  import lpc_resp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lframe_n,
  input  logic [3:0]        lad_in,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic              req_dma,
  output logic [ADDR_W-1:0] req_addr,
  output logic [2:0]        req_chan,
  output logic              req_tc,
  output logic              req_last,
  output logic [7:0]        req_wdata,
  input  logic              rsp_err,
  input  logic [7:0]        rsp_rdata
);
  localparam int ADDR_NIBS = ADDR_W / 4;

  st_e        state;
  logic       is_dma, is_write, more_q, err_q, hs;
  logic [7:0] rdata;

  assign hs        = req_valid && req_ready && lframe_n;
  assign req_write = is_write;
  assign req_dma   = is_dma;

  lpc_resp_fsm #(.ADDR_NIBS(ADDR_NIBS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_in(lad_in),
    .req_ready(req_ready), .rsp_err(rsp_err), .state(state),
    .is_dma(is_dma), .is_write(is_write), .more_q(more_q), .err_q(err_q),
    .req_valid(req_valid), .req_last(req_last)
  );

  lpc_resp_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .state(state),
    .lad_in(lad_in), .hs(hs), .rsp_rdata(rsp_rdata), .addr(req_addr),
    .chan(req_chan), .tc(req_tc), .wdata(req_wdata), .rdata(rdata)
  );

  lpc_resp_drive u_drv (
    .state(state), .is_dma(is_dma), .more_q(more_q), .err_q(err_q),
    .rdata(rdata), .lad_out(lad_out), .lad_oe(lad_oe)
  );

endmodule

// File: rtl/lpc_resp_chk.sv
module lpc_resp_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lframe_n,
  input logic [3:0]        lad_out,
  input logic              lad_oe,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              req_dma,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_last,
  input logic [7:0]        req_wdata,
  input logic              rsp_err
);
  logic err_seen;

  always_ff @(posedge clk) begin
    if (!rst_n || !lframe_n) err_seen <= 1'b0;
    else if (req_valid && req_ready && rsp_err) err_seen <= 1'b1;
  end

  // R11
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |=> (!lad_oe && !req_valid));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && lframe_n) |=>
      (req_valid && $stable(req_addr) && $stable(req_wdata) &&
       $stable(req_write) && $stable(req_dma)));

  // R6
  ready_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && lframe_n) |=>
      (lad_oe && (lad_out == 4'b0000 || lad_out == 4'b1001 || lad_out == 4'b1010)));

  // R5
  long_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lad_oe && req_valid && lad_out == 4'b0110) |-> !req_dma);

  // R5
  short_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lad_oe && req_valid && lad_out == 4'b0101) |-> req_dma);

  // R8
  io_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_dma) |-> req_last);

  // R9
  err_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_seen |-> !req_valid);

endmodule

bind lpc_resp lpc_resp_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_out(lad_out),
  .lad_oe(lad_oe), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_dma(req_dma), .req_addr(req_addr),
  .req_last(req_last), .req_wdata(req_wdata), .rsp_err(rsp_err)
);

// File: tb/sim_lpc_resp.sv
module sim_lpc_resp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lframe_n = 1'b1;
  logic [3:0]  lad_in = 4'hF;
  logic [3:0]  lad_out;
  logic        lad_oe, req_valid, req_write, req_dma, req_tc, req_last;
  logic        req_ready = 1'b0;
  logic [15:0] req_addr;
  logic [2:0]  req_chan;
  logic [7:0]  req_wdata;
  logic        rsp_err = 1'b0;
  logic [7:0]  rsp_rdata = 8'h00;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] b_dat [4];
  int         b_lat [4];
  bit         b_err [4];

  always #10 clk = ~clk;

  lpc_resp u0 (
    .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_dma(req_dma),
    .req_addr(req_addr), .req_chan(req_chan), .req_tc(req_tc),
    .req_last(req_last), .req_wdata(req_wdata), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One bus clock: compare the outputs of the current state, then drive this clock's inputs.
  task automatic phase(input logic fr, input logic [3:0] lad, input logic eoe,
                       input logic [3:0] eout, input logic evld, input string tag,
                       input logic rdy = 1'b0);
    @(negedge clk);
    check(tag, "lad_oe", 32'(lad_oe), 32'(eoe));
    if (eoe) check(tag, "lad_out", 32'(lad_out), 32'(eout));
    check(tag, "req_valid", 32'(req_valid), 32'(evld));
    lframe_n  = fr;
    lad_in    = lad;
    req_ready = rdy;
  endtask

  task automatic set_byte(input int i, input logic [7:0] d, input int l, input bit e);
    b_dat[i] = d; b_lat[i] = l; b_err[i] = e;
  endtask

  task automatic quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) phase(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, tag);
  endtask

  task automatic xfer(input bit dma, input bit wr, input logic [15:0] addr,
                      input logic [3:0] chan, input logic [1:0] size);
    int n;
    n = !dma ? 1 : (size == 2'b00) ? 1 : (size == 2'b01) ? 2 : 4;
    phase(1'b0, 4'h0, 1'b0, 4'h0, 1'b0, "R2 start");
    phase(1'b1, {dma, 1'b0, wr, 1'b0}, 1'b0, 4'h0, 1'b0, "R2 type");
    if (dma) begin
      phase(1'b1, chan, 1'b0, 4'h0, 1'b0, "R8 chan");
      phase(1'b1, {2'b00, size}, 1'b0, 4'h0, 1'b0, "R8 size");
    end else begin
      for (int i = 0; i < 4; i++)
        phase(1'b1, addr[15-4*i -: 4], 1'b0, 4'h0, 1'b0, "R3 addr");
    end
    for (int b = 0; b < n; b++) begin
      bit last, stop;
      logic [3:0] code, wcode;
      last  = (b == n - 1);
      stop  = b_err[b] || last;
      code  = b_err[b] ? 4'hA : ((dma && !last) ? 4'h9 : 4'h0);
      wcode = dma ? 4'h5 : 4'h6;
      if (wr) begin
        phase(1'b1, b_dat[b][3:0], 1'b0, 4'h0, 1'b0, "R3 wdata lo");
        phase(1'b1, b_dat[b][7:4], 1'b0, 4'h0, 1'b0, "R3 wdata hi");
      end
      phase(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, "R4 tar1");
      rsp_err   = b_err[b];
      rsp_rdata = wr ? 8'h00 : b_dat[b];
      phase(1'b1, 4'hF, 1'b0, 4'h0, 1'b1, "R4 tar2 request", b_lat[b] == 0);
      check("R4 field", "req_write", 32'(req_write), 32'(wr));
      check("R4 field", "req_dma", 32'(req_dma), 32'(dma));
      check("R8 field", "req_last", 32'(req_last), 32'(last));
      if (dma) begin
        check("R8 field", "req_chan", 32'(req_chan), 32'(chan[2:0]));
        check("R8 field", "req_tc", 32'(req_tc), 32'(chan[3]));
      end else begin
        check("R3 field", "req_addr", 32'(req_addr), 32'(addr));
      end
      if (wr) check("R3 field", "req_wdata", 32'(req_wdata), 32'(b_dat[b]));
      for (int k = 1; k <= b_lat[b]; k++)
        phase(1'b1, 4'hF, 1'b1, wcode, 1'b1, "R5 wait", k == b_lat[b]);
      phase(1'b1, 4'hF, 1'b1, code, 1'b0, b_err[b] ? "R6 error code" : "R6 ready code");
      if (!wr) begin
        phase(1'b1, 4'hF, 1'b1, b_dat[b][3:0], 1'b0, "R7 rdata lo");
        phase(1'b1, 4'hF, 1'b1, b_dat[b][7:4], 1'b0, "R7 rdata hi");
      end
      if (wr || stop) begin
        phase(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, b_err[b] ? "R9 end" : "R10 end1");
        phase(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, b_err[b] ? "R9 end" : "R10 end2");
      end
      if (stop) break;
    end
    phase(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, "R10 idle");
    rsp_err = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", "lad_oe", 32'(lad_oe), 32'd0);
    check("R1 reset", "req_valid", 32'(req_valid), 32'd0);
    rst_n = 1'b1;
    phase(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, "R1 after reset");

    // I/O read, no stall
    set_byte(0, 8'hA5, 0, 1'b0);
    xfer(1'b0, 1'b0, 16'h1234, 4'h0, 2'b00);
    // I/O write, three-clock stall
    set_byte(0, 8'h3C, 3, 1'b0);
    xfer(1'b0, 1'b1, 16'h02F8, 4'h0, 2'b00);
    // I/O read with error: data still follows
    set_byte(0, 8'h77, 1, 1'b1);
    xfer(1'b0, 1'b0, 16'hBEEF, 4'h0, 2'b00);
    // I/O write with error
    set_byte(0, 8'h5A, 0, 1'b1);
    xfer(1'b0, 1'b1, 16'h0060, 4'h0, 2'b00);
    // I/O read with a long stall
    set_byte(0, 8'hC3, 20, 1'b0);
    xfer(1'b0, 1'b0, 16'h0378, 4'h0, 2'b00);
    // DMA read, four bytes
    set_byte(0, 8'h11, 0, 1'b0); set_byte(1, 8'h52, 2, 1'b0);
    set_byte(2, 8'h9D, 1, 1'b0); set_byte(3, 8'hE6, 0, 1'b0);
    xfer(1'b1, 1'b0, 16'h0, 4'h3, 2'b11);
    // DMA write, two bytes, terminal count set
    set_byte(0, 8'h4B, 1, 1'b0); set_byte(1, 8'hF0, 0, 1'b0);
    xfer(1'b1, 1'b1, 16'h0, 4'hD, 2'b01);
    // DMA read, four bytes, error on the second: R9
    set_byte(0, 8'h21, 0, 1'b0); set_byte(1, 8'h87, 2, 1'b1);
    set_byte(2, 8'h00, 0, 1'b0); set_byte(3, 8'h00, 0, 1'b0);
    xfer(1'b1, 1'b0, 16'h0, 4'h1, 2'b10);
    quiet(6, "R9 no further request");
    // DMA write, four bytes, error on the first: R9
    set_byte(0, 8'h6E, 1, 1'b1);
    xfer(1'b1, 1'b1, 16'h0, 4'h6, 2'b11);
    quiet(6, "R9 no further request");
    // DMA write, one byte
    set_byte(0, 8'h99, 0, 1'b0);
    xfer(1'b1, 1'b1, 16'h0, 4'h2, 2'b00);

    // R2: bad start nibble, then a well-formed tail is ignored
    phase(1'b0, 4'h3, 1'b0, 4'h0, 1'b0, "R2 bad start");
    phase(1'b1, 4'h0, 1'b0, 4'h0, 1'b0, "R2 bad start");
    quiet(8, "R2 ignored after bad start");
    // R2: unsupported cycle type
    phase(1'b0, 4'h0, 1'b0, 4'h0, 1'b0, "R2 start");
    phase(1'b1, 4'h4, 1'b0, 4'h0, 1'b0, "R2 bad type");
    quiet(10, "R2 ignored after bad type");

    // R11: abort during wait states
    phase(1'b0, 4'h0, 1'b0, 4'h0, 1'b0, "R11 start");
    phase(1'b1, 4'h0, 1'b0, 4'h0, 1'b0, "R11 type");
    for (int i = 0; i < 4; i++) phase(1'b1, 4'h1, 1'b0, 4'h0, 1'b0, "R11 addr");
    phase(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, "R11 tar1");
    phase(1'b1, 4'hF, 1'b0, 4'h0, 1'b1, "R11 tar2");
    phase(1'b1, 4'hF, 1'b1, 4'h6, 1'b1, "R11 wait");
    phase(1'b0, 4'hF, 1'b1, 4'h6, 1'b1, "R11 wait then abort", 1'b1);
    phase(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, "R11 released after abort");
    quiet(4, "R11 idle after abort");
    // R11: new start during address collection restarts the cycle
    phase(1'b0, 4'h0, 1'b0, 4'h0, 1'b0, "R11 start");
    phase(1'b1, 4'h2, 1'b0, 4'h0, 1'b0, "R11 type");
    phase(1'b1, 4'h7, 1'b0, 4'h0, 1'b0, "R11 addr");
    phase(1'b1, 4'h7, 1'b0, 4'h0, 1'b0, "R11 addr");
    set_byte(0, 8'hD2, 1, 1'b0);
    xfer(1'b0, 1'b0, 16'h4321, 4'h0, 2'b00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule